// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets synchronous logic reach an asynchronous static RAM that has two chip enables of opposite polarity (one active-low, one active-high), an active-low output enable and an active-low write enable. A client hands it one read or one write at a time over a valid/ready command port, with an address, write data and a direction bit. The block then drives the RAM pins through fixed phases. Each phase lasts a programmable number of clock cycles, which is how address setup, write pulse width, data setup and hold, and write recovery are met.

Every access runs the same phases in the same order. In the setup phase both chip enables are asserted and the address is steady. The main phase follows: a write-enable pulse for a write, or an output-enable window for a read. The recovery phase comes last; here the enables and the address are held. For a write, the data bus is driven over all three phases, so write data is valid before the write window opens and stays valid after it closes. For a read, the RAM output is sampled at the end of the output-enable window and handed back with a one-cycle strobe. Between accesses both chip enables are released, which puts the RAM in power-down.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and with no request pending, `req_ready_o`=1, `sram_ce_n_o`=1, `sram_ce_o`=0, `sram_we_n_o`=1, `sram_oe_n_o`=1, `sram_dq_oe_o`=0 and `rsp_valid_o`=0.
- R2: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both 1. The setup phase follows for max(`cfg_setup_i`,1) cycles. In this phase `sram_ce_n_o`=0, `sram_ce_o`=1, `sram_we_n_o`=1 and `sram_oe_n_o`=1, and `sram_addr_o` equals the request address.
- R3: For a write (`req_write_i`=1), `sram_we_n_o` is 0 for exactly max(`cfg_pulse_i`,1) consecutive cycles. It is low only while `sram_ce_n_o`=0 and `sram_ce_o`=1, and `sram_oe_n_o` stays 1 during a write.
- R4: After the write pulse or read window ends, the chip enables stay asserted and `sram_addr_o` stays unchanged for max(`cfg_recov_i`,1) cycles. The block then returns to idle.
- R5: `sram_dq_oe_o` is 1 with `sram_dq_o` equal to the write data in every cycle of a write access (setup, pulse and recovery). It is 0 in every cycle of a read. It is never 1 while `sram_oe_n_o` is 0.
- R6: For a read (`req_write_i`=0), `sram_oe_n_o` is 0 for exactly max(`cfg_access_i`,1) cycles. `sram_dq_i` is sampled on the edge that ends that window. `rsp_valid_o` is 1 for exactly one cycle, the first recovery cycle, with `rsp_rdata_o` holding the sampled data. Writes never raise `rsp_valid_o`.
- R7: `req_ready_o` falls in the cycle after acceptance and stays 0 for the whole access. That is setup + main + recovery cycles.
- R8: A timing count of 0 behaves as a count of 1.
- R9: Whenever `req_ready_o` is 1, both chip enables are deasserted (power-down), write enable and output enable are high, and the data bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Write data |
| cfg_setup_i | input | CNT_W | Setup phase cycles |
| cfg_pulse_i | input | CNT_W | Write pulse cycles |
| cfg_access_i | input | CNT_W | Read window cycles |
| cfg_recov_i | input | CNT_W | Recovery phase cycles |
| rsp_valid_o | output | 1 | Read data strobe |
| rsp_rdata_o | output | DATA_W | Read data |
| sram_addr_o | output | ADDR_W | RAM address |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_ce_o | output | 1 | Chip enable, active high |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_dq_o | output | DATA_W | Data toward RAM |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | DATA_W | Data from RAM |

## Verification
Two things happen in the same cycle: the read-data strobe and the first cycle of address hold in recovery. The response leaves on the edge that also closes the output-enable window. Reads are issued with random window and recovery lengths, including a count of zero. For each read, the bench checks that exactly one strobe appears and that it carries the value last written to that address. It also checks that the address and chip enables do not move in that cycle and that the recovery length is still the full programmed count.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_PULSE  = 3'd2,
    PH_ACCESS = 3'd3,
    PH_RECOV  = 3'd4
  } phase_e;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  // length 0 is taken as 1: counter loads len-1, saturating at 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  phase_e phase_i,
  input  logic   write_i,
  output logic   ce_n_o,
  output logic   ce_o,
  output logic   we_n_o,
  output logic   oe_n_o,
  output logic   dq_oe_o
);
  logic active;
  assign active  = (phase_i != PH_IDLE);
  assign ce_n_o  = ~active;
  assign ce_o    = active;
  assign we_n_o  = ~(phase_i == PH_PULSE);
  assign oe_n_o  = ~(phase_i == PH_ACCESS);
  // bus driven across setup, pulse and recovery of a write only
  assign dq_oe_o = active & write_i;
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [CNT_W-1:0]  cfg_setup_i,
  input  logic [CNT_W-1:0]  cfg_pulse_i,
  input  logic [CNT_W-1:0]  cfg_access_i,
  input  logic [CNT_W-1:0]  cfg_recov_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_n_o,
  output logic              sram_ce_o,
  output logic              sram_oe_n_o,
  output logic              sram_we_n_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  phase_e            phase_q, phase_d;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              tmr_load, tmr_done, accept, cap;
  logic [CNT_W-1:0]  tmr_len;

  assign req_ready_o = (phase_q == PH_IDLE);
  assign accept      = req_valid_i & req_ready_o;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_len  = cfg_setup_i;
    cap      = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d  = PH_SETUP;
        tmr_load = 1'b1;
        tmr_len  = cfg_setup_i;
      end
      PH_SETUP: if (tmr_done) begin
        phase_d  = wr_q ? PH_PULSE : PH_ACCESS;
        tmr_load = 1'b1;
        tmr_len  = wr_q ? cfg_pulse_i : cfg_access_i;
      end
      PH_PULSE, PH_ACCESS: if (tmr_done) begin
        phase_d  = PH_RECOV;
        tmr_load = 1'b1;
        tmr_len  = cfg_recov_i;
        cap      = (phase_q == PH_ACCESS);
      end
      PH_RECOV: if (tmr_done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        wr_q    <= req_write_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .len_i (tmr_len),
    .done_o(tmr_done)
  );

  sram_pin_decode u_pins (
    .phase_i(phase_q),
    .write_i(wr_q),
    .ce_n_o (sram_ce_n_o),
    .ce_o   (sram_ce_o),
    .we_n_o (sram_we_n_o),
    .oe_n_o (sram_oe_n_o),
    .dq_oe_o(sram_dq_oe_o)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .dq_i   (sram_dq_i),
    .valid_o(rsp_valid_o),
    .rdata_o(rsp_rdata_o)
  );

  assign sram_addr_o = addr_q;
  assign sram_dq_o   = wdata_q;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_n_o,
  input logic              sram_ce_o,
  input logic              sram_oe_n_o,
  input logic              sram_we_n_o,
  input logic              sram_dq_oe_o
);
  assert_write_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> (!sram_ce_n_o && sram_ce_o && sram_oe_n_o && sram_dq_oe_o));

  assert_no_contention_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o);

  assert_power_down_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_n_o && !sram_ce_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o));

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_n_o && $past(!sram_ce_n_o)) |-> $stable(sram_addr_o));

  assert_rsp_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_after_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(!sram_oe_n_o) && sram_oe_n_o && !sram_ce_n_o));

  assert_busy_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;
  localparam int AW = 8, DW = 8, CW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] c_setup = 4'd1, c_pulse = 4'd1, c_access = 4'd1, c_recov = 4'd1;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] s_addr;
  logic s_ce_n, s_ce, s_oe_n, s_we_n, s_dq_oe;
  logic [DW-1:0] s_dq_o, s_dq_i;

  int checks = 0, fails = 0;
  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  always #5 clk = ~clk;

  sram_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_sram_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cfg_setup_i(c_setup), .cfg_pulse_i(c_pulse), .cfg_access_i(c_access), .cfg_recov_i(c_recov),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_addr_o(s_addr), .sram_ce_n_o(s_ce_n), .sram_ce_o(s_ce),
    .sram_oe_n_o(s_oe_n), .sram_we_n_o(s_we_n),
    .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe), .sram_dq_i(s_dq_i)
  );

  // RAM model: drives only in read mode, writes during the three-way overlap
  assign s_dq_i = (!s_ce_n && s_ce && !s_oe_n && s_we_n) ? ram[s_addr] : 8'hEE;
  always @(posedge clk) if (!s_ce_n && s_ce && !s_we_n && s_dq_oe) ram[s_addr] <= s_dq_o;

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, req_ready, req_ready, 1);
    chk(req, s_ce_n && !s_ce, {s_ce_n, s_ce}, 2);
    chk(req, s_we_n && s_oe_n, {s_we_n, s_oe_n}, 3);
    chk(req, !s_dq_oe, s_dq_oe, 0);
    chk(req, !rsp_valid, rsp_valid, 0);
  endtask

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n_set = 0, n_main = 0, n_rec = 0, n_busy = 0, n_rsp = 0, phase = 0;
    logic addr_ok = 1'b1, bus_ok = 1'b1, en_ok = 1'b1, seen_ready_low;
    logic [DW-1:0] got = '0;
    @(negedge clk);
    chk("R9", req_ready, req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    seen_ready_low = !req_ready;
    req_addr = ~a; req_wdata = ~d;  // inputs move; pins must not
    while (!req_ready) begin
      n_busy++;
      if (s_addr != a) addr_ok = 1'b0;
      if (s_ce_n || !s_ce) en_ok = 1'b0;
      if (s_dq_oe != wr || (wr && s_dq_o != d) || (s_dq_oe && !s_oe_n)) bus_ok = 1'b0;
      if (!s_we_n || !s_oe_n) begin
        phase = 1; n_main++;
        if (wr && !s_oe_n) bus_ok = 1'b0;
        if (!wr && !s_we_n) bus_ok = 1'b0;
      end else if (phase == 0) n_set++;
      else n_rec++;
      if (rsp_valid) begin
        n_rsp++; got = rsp_rdata;
        if (n_rec != 1) chk("R6 strobe in first recovery cycle", 1'b0, n_rec, 1);
      end
      @(negedge clk);
      if (n_busy > 100) break;
    end
    chk("R7 ready low after accept", seen_ready_low, !seen_ready_low, 0);
    chk("R2 setup cycles", n_set == eff(c_setup), n_set, eff(c_setup));
    if (wr) chk("R3 write pulse cycles", n_main == eff(c_pulse), n_main, eff(c_pulse));
    else    chk("R6 read window cycles", n_main == eff(c_access), n_main, eff(c_access));
    chk("R4 recovery cycles", n_rec == eff(c_recov), n_rec, eff(c_recov));
    chk("R7 busy length", n_busy == n_set + n_main + n_rec, n_busy, n_set + n_main + n_rec);
    chk("R4 address held", addr_ok, addr_ok, 1);
    chk("R2 enables asserted", en_ok, en_ok, 1);
    chk("R5 data bus", bus_ok, bus_ok, 1);
    if (wr) begin
      shadow[a] = d;
      chk("R6 no strobe on write", n_rsp == 0, n_rsp, 0);
    end else begin
      chk("R6 one strobe", n_rsp == 1, n_rsp, 1);
      chk("R6 read data", got == shadow[a], got, shadow[a]);
    end
    check_idle("R9 idle after access");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = DW'(i) ^ 8'h5A;
      shadow[i] = DW'(i) ^ 8'h5A;
    end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    // directed: all counts zero behave as one
    c_setup = 0; c_pulse = 0; c_access = 0; c_recov = 0;
    access(1'b1, 8'h10, 8'hA5);
    access(1'b0, 8'h10, 8'h00);
    chk("R8 zero counts", 1'b1, 0, 0);
    // directed: maximum counts, boundary addresses
    c_setup = 15; c_pulse = 15; c_access = 15; c_recov = 15;
    access(1'b1, 8'hFF, 8'h3C);
    access(1'b0, 8'hFF, 8'h00);
    access(1'b0, 8'h00, 8'h00);
    // random mix
    for (int k = 0; k < 80; k++) begin
      c_setup  = CW'($urandom_range(0, 5));
      c_pulse  = CW'($urandom_range(0, 5));
      c_access = CW'($urandom_range(0, 5));
      c_recov  = CW'($urandom_range(0, 5));
      access(1'($urandom_range(0, 1)), AW'($urandom_range(0, 15)), DW'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule